// File: doc/BRIEF.md
# Sprite Attribute Table Copy Engine

This block fills the 160-byte sprite attribute table at 0xFE00–0xFE9F from any 256-byte page of the system address space. The processor writes a page number into an 8-bit register. After a one-cycle arming delay the engine reads the page byte by byte through its memory read port and writes each byte into attribute memory, one byte per machine cycle. Because a read and a write are pipelined through a one-byte buffer, the transfer needs 161 active cycles: the first cycle only fetches, and the last one only stores.

While the engine runs it holds the external bus it reads from. A processor read that targets the same bus is therefore steered to the address the engine is reading in that cycle. Two bus-region maps are available and an input selects between them. In the colour map the low, video and external regions are separate buses. In the monochrome map the low region and the external region share one bus. A halt input freezes all progress, and a new page written mid-transfer restarts the copy without dropping the busy flag.

Top module: `sprite_attr_dma`

## Requirements
- R1: After reset the page register reads 0xFF, `busy` is low, and neither `oam_wr_en` nor `cpu_conflict` is high.
- R2: A write on `page_wr_en` stores `page_wr_data`. From the next cycle `page_rd_data` returns the stored value, and it holds that value until the next write.
- R3: The clock edge after a register write that is not halted latches the page and starts the transfer. In the first busy cycle `oam_wr_en` is low and `mem_rd_addr` equals page×256+0.
- R4: A transfer writes attribute addresses 0xFE00+k, for k = 0..159, in increasing order with no gaps. The byte written to 0xFE00+k is the one that `mem_rd_data` returned for address page×256+k.
- R5: Without halts, `busy` stays high for exactly 161 cycles from the start of a fresh transfer, then falls.
- R6: In any cycle where `cpu_halt` is high, the counter and read buffer do not change and `oam_wr_en` and `mem_rd_en` are low. When `cpu_halt` is released the transfer continues at the same offset and completes all 160 bytes.
- R7: A page written while a transfer is running keeps `busy` high continuously. The old transfer writes one more byte after the write cycle, and then the new page is copied from offset 0.
- R8: With `color_model`=1, a conflict occurs while busy only when the source page and `cpu_addr[15:8]` lie in the same region. The regions are low (0x00–0x7F), video (0x80–0x9F) and external (0xA0–0xFD). High bytes 0xFE–0xFF never conflict.
- R9: With `color_model`=0, the low and external regions form one region, so a page in either conflicts with an address in either. The video region conflicts only with itself.
- R10: On a conflict, `cpu_eff_addr` equals `mem_rd_addr`, the engine's current read address. Otherwise `cpu_eff_addr` equals `cpu_addr`. No conflict is reported while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_halt | input | 1 | Freezes all engine progress while high |
| color_model | input | 1 | 1 selects the colour bus map, 0 the monochrome map |
| page_wr_en | input | 1 | Processor write strobe for the page register |
| page_wr_data | input | 8 | Source page number to write |
| page_rd_data | output | 8 | Current page register value |
| busy | output | 1 | High while a transfer is in flight |
| mem_rd_en | output | 1 | The engine fetches a source byte this cycle |
| mem_rd_addr | output | 16 | Engine's current source address |
| mem_rd_data | input | 8 | Source byte returned for `mem_rd_addr` |
| oam_wr_en | output | 1 | Attribute memory write strobe |
| oam_wr_addr | output | 16 | Attribute memory write address |
| oam_wr_data | output | 8 | Attribute memory write data |
| cpu_addr | input | 16 | Processor read address |
| cpu_eff_addr | output | 16 | Processor read address after conflict steering |
| cpu_conflict | output | 1 | Processor read collides with the engine's bus |

## Verification
The embedded properties check these behaviours on every cycle: the register store, the counter load at start, the halt freeze, and the step-by-one progression of write addresses inside the attribute window. They also check that busy falls after the last byte and that conflicts occur only during a transfer. Some behaviours can only be shown by the bench scenarios. These are the data carried from each source address into the matching attribute slot, the 161-cycle busy length, and the exact truncation point and zero-gap handover of a restart. The scenarios also cover resuming after halts, and the full conflict tables of both bus maps measured against a separately written region model.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    RG_LOW  = 2'd0,
    RG_VRAM = 2'd1,
    RG_EXT  = 2'd2,
    RG_NONE = 2'd3
  } bus_region_e;

  // Classify an address high byte into the bus it lives on.
  function automatic bus_region_e region_of(input logic [7:0] hi);
    if (hi < 8'h80)       return RG_LOW;
    else if (hi <= 8'h9F) return RG_VRAM;
    else if (hi <= 8'hFD) return RG_EXT;
    else                  return RG_NONE;
  endfunction

  // True when the engine's page and a processor address share one bus.
  function automatic logic conflict_hit(input logic [7:0] page,
                                        input logic [7:0] hi,
                                        input logic       color);
    bus_region_e a;
    bus_region_e b;
    a = region_of(page);
    b = region_of(hi);
    if (!color) begin
      if (a == RG_EXT) a = RG_LOW;
      if (b == RG_EXT) b = RG_LOW;
    end
    return (a != RG_NONE) && (a == b);
  endfunction

endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer #(
  parameter int XFER_LEN = 160,
  parameter int PAGE_W   = 8,
  parameter int OFS_W    = 8,
  parameter int CNT_W    = $clog2(XFER_LEN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_halt,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] page_reg,
  output logic [PAGE_W-1:0] src_page,
  output logic              busy,
  output logic              mem_re,
  output logic [OFS_W-1:0]  rd_ofs,
  input  logic [7:0]        mem_data,
  output logic              oam_we,
  output logic [OFS_W-1:0]  oam_ofs,
  output logic [7:0]        oam_data
);

  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(XFER_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_V  = CNT_W'(XFER_LEN);

  logic             delay_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       buf_q;

  // Named internal events for the properties.
  logic advance, active, do_write, do_read, start_fire;

  // Offset of the byte fetched this cycle.
  function automatic logic [OFS_W-1:0] fetch_ofs(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : OFS_W'(LOAD_V - c);
  endfunction

  // Offset of the byte stored this cycle.
  function automatic logic [OFS_W-1:0] store_ofs(input logic [CNT_W-1:0] c);
    return OFS_W'(LEN_V - c);
  endfunction

  assign advance    = !cpu_halt;
  assign active     = (cnt_q != '0);
  assign do_write   = active && (cnt_q <= LEN_V);
  assign do_read    = (cnt_q >= CNT_W'(2));
  assign start_fire = advance && delay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_reg <= '1;
      src_page <= '1;
      delay_q  <= 1'b0;
      hold_q   <= 1'b0;
      cnt_q    <= '0;
      buf_q    <= '0;
    end else begin
      if (wr_en) begin
        page_reg <= wr_page;
        delay_q  <= 1'b1;
        hold_q   <= active | (delay_q & hold_q);
      end else if (start_fire) begin
        delay_q  <= 1'b0;
        hold_q   <= 1'b0;
      end
      if (advance) begin
        if (start_fire) begin
          src_page <= page_reg;
          cnt_q    <= LOAD_V;
        end else if (active) begin
          cnt_q    <= cnt_q - 1'b1;
        end
        if (do_read) buf_q <= mem_data;
      end
    end
  end

  assign busy     = active | hold_q;
  assign mem_re   = do_read && advance;
  assign rd_ofs   = fetch_ofs(cnt_q);
  assign oam_we   = do_write && advance;
  assign oam_ofs  = store_ofs(cnt_q);
  assign oam_data = buf_q;

  // R2
  page_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> page_reg == $past(wr_page));

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> cnt_q == LOAD_V);

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> $stable(cnt_q) && $stable(buf_q));

  // R4
  store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oam_we && cnt_q > CNT_W'(1) && !start_fire) |=>
      (cpu_halt || (oam_we && oam_ofs == $past(oam_ofs) + 1'b1)));

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cnt_q == CNT_W'(1) && !delay_q && !wr_en) |=> !busy);

endmodule

// File: rtl/sdma_conflict.sv
module sdma_conflict #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_model,
  input  logic              busy,
  input  logic [PAGE_W-1:0] src_page,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              conflict,
  output logic [ADDR_W-1:0] eff_addr
);
  import sdma_pkg::*;

  assign conflict = busy && conflict_hit(src_page, cpu_addr[ADDR_W-1 -: PAGE_W], color_model);
  assign eff_addr = conflict ? dma_addr : cpu_addr;

  // R10
  conflict_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> busy);

  // R8
  page_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> eff_addr[ADDR_W-1 -: PAGE_W] == src_page);

endmodule

// File: rtl/sprite_attr_dma.sv
module sprite_attr_dma #(
  parameter int                XFER_LEN = 160,
  parameter int                ADDR_W   = 16,
  parameter int                PAGE_W   = 8,
  parameter logic [ADDR_W-1:0] OAM_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_halt,
  input  logic              color_model,
  input  logic              page_wr_en,
  input  logic [PAGE_W-1:0] page_wr_data,
  output logic [PAGE_W-1:0] page_rd_data,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              oam_wr_en,
  output logic [ADDR_W-1:0] oam_wr_addr,
  output logic [7:0]        oam_wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] cpu_eff_addr,
  output logic              cpu_conflict
);

  localparam int                OFS_W   = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] OAM_END = ADDR_W'(OAM_BASE + XFER_LEN);

  logic [PAGE_W-1:0] src_page;
  logic [OFS_W-1:0]  rd_ofs, oam_ofs;

  sdma_sequencer #(
    .XFER_LEN(XFER_LEN),
    .PAGE_W  (PAGE_W),
    .OFS_W   (OFS_W)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_halt(cpu_halt),
    .wr_en   (page_wr_en),
    .wr_page (page_wr_data),
    .page_reg(page_rd_data),
    .src_page(src_page),
    .busy    (busy),
    .mem_re  (mem_rd_en),
    .rd_ofs  (rd_ofs),
    .mem_data(mem_rd_data),
    .oam_we  (oam_wr_en),
    .oam_ofs (oam_ofs),
    .oam_data(oam_wr_data)
  );

  assign mem_rd_addr = {src_page, rd_ofs};
  assign oam_wr_addr = OAM_BASE + ADDR_W'(oam_ofs);

  sdma_conflict #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) conf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .color_model(color_model),
    .busy       (busy),
    .src_page   (src_page),
    .dma_addr   (mem_rd_addr),
    .cpu_addr   (cpu_addr),
    .conflict   (cpu_conflict),
    .eff_addr   (cpu_eff_addr)
  );

  // R4
  oam_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_wr_en |-> (oam_wr_addr >= OAM_BASE) && (oam_wr_addr < OAM_END));

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> !oam_wr_en && !mem_rd_en);

endmodule

// File: tb/sprite_attr_dma_tb.sv
module sprite_attr_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_halt = 1'b0;
  logic        color_model = 1'b1;
  logic        page_wr_en = 1'b0;
  logic [7:0]  page_wr_data = 8'h00;
  logic [7:0]  page_rd_data;
  logic        busy;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        oam_wr_en;
  logic [15:0] oam_wr_addr;
  logic [7:0]  oam_wr_data;
  logic [15:0] cpu_addr = 16'h0000;
  logic [15:0] cpu_eff_addr;
  logic        cpu_conflict;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] exp_addr_q[$];
  logic [7:0]  exp_data_q[$];

  always #5 clk = ~clk;

  // Source memory pattern, depends on both address bytes.
  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ (a[15:8] + 8'h3C);
  endfunction

  assign mem_rd_data = pat(mem_rd_addr);

  sprite_attr_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_halt(cpu_halt), .color_model(color_model),
    .page_wr_en(page_wr_en), .page_wr_data(page_wr_data), .page_rd_data(page_rd_data),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .oam_wr_en(oam_wr_en), .oam_wr_addr(oam_wr_addr), .oam_wr_data(oam_wr_data),
    .cpu_addr(cpu_addr), .cpu_eff_addr(cpu_eff_addr), .cpu_conflict(cpu_conflict)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Independent bus map: 1 = low bus, 2 = video, 3 = external, 0 = none.
  function automatic int bus_id(input logic [7:0] hi, input bit color);
    if (hi <= 8'h7F) return 1;
    if (hi >= 8'h80 && hi <= 8'h9F) return 2;
    if (hi >= 8'hA0 && hi <= 8'hFD) return color ? 3 : 1;
    return 0;
  endfunction

  function automatic bit ref_conf(input logic [7:0] p, input logic [15:0] a, input bit color);
    return (bus_id(p, color) != 0) && (bus_id(p, color) == bus_id(a[15:8], color));
  endfunction

  // Driver side of the scoreboard.
  task automatic push_exp(input logic [7:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      exp_addr_q.push_back(16'hFE00 + 16'(k));
      exp_data_q.push_back(pat({p, 8'(k)}));
    end
  endtask

  task automatic reg_write(input logic [7:0] p);
    @(negedge clk);
    page_wr_en   = 1'b1;
    page_wr_data = p;
    @(negedge clk);
    page_wr_en   = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    #2;
    while (busy) begin
      @(negedge clk);
      #2;
    end
    check(exp_addr_q.size() == 0, "R4", "all expected stores seen", exp_addr_q.size(), 0);
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    #1;
    if (rst_n && oam_wr_en) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R4", "unexpected store", oam_wr_addr, 0);
      end else begin
        logic [15:0] ea;
        logic [7:0]  ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        check(oam_wr_addr == ea, "R4", "store address", oam_wr_addr, ea);
        check(oam_wr_data == ed, "R4", "store data", oam_wr_data, ed);
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      check(1'b0, "R5", "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    logic [15:0] hold_addr;
    logic [15:0] hold_rd;
    int          busy_len;
    logic [15:0] addrs [7];
    logic [7:0]  pages [3];
    addrs = '{16'h3456, 16'h9000, 16'hB000, 16'hFF80, 16'h0000, 16'hFDFF, 16'h8000};
    pages = '{8'h12, 8'h85, 8'hC3};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check(page_rd_data == 8'hFF, "R1", "page after reset", page_rd_data, 8'hFF);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(oam_wr_en == 1'b0, "R1", "store after reset", oam_wr_en, 0);
    cpu_addr = 16'hFE10;
    #1;
    check(cpu_conflict == 1'b0, "R1", "conflict after reset", cpu_conflict, 0);

    // Fresh transfer: R2, R3, R5
    push_exp(8'h12, 160);
    reg_write(8'h12);
    #2;
    check(page_rd_data == 8'h12, "R2", "page readback", page_rd_data, 8'h12);
    check(busy == 1'b0, "R3", "busy in delay cycle", busy, 0);
    @(negedge clk); #2;
    check(busy == 1'b1, "R3", "busy after delay", busy, 1);
    check(oam_wr_en == 1'b0, "R3", "prime cycle stores nothing", oam_wr_en, 0);
    check(mem_rd_addr == 16'h1200, "R3", "prime read address", mem_rd_addr, 16'h1200);
    check(mem_rd_en == 1'b1, "R3", "prime read enable", mem_rd_en, 1);
    busy_len = 1;
    @(negedge clk); #2;
    while (busy) begin
      busy_len++;
      @(negedge clk); #2;
    end
    check(busy_len == 161, "R5", "busy length", busy_len, 161);
    check(exp_addr_q.size() == 0, "R4", "queue drained", exp_addr_q.size(), 0);
    check(page_rd_data == 8'h12, "R2", "page held", page_rd_data, 8'h12);
    cpu_addr = 16'h1234;
    #1;
    check(cpu_conflict == 1'b0, "R10", "idle no conflict", cpu_conflict, 0);
    check(cpu_eff_addr == 16'h1234, "R10", "idle pass-through", cpu_eff_addr, 16'h1234);

    // Halt: R6
    push_exp(8'h40, 160);
    reg_write(8'h40);
    repeat (20) @(negedge clk);
    cpu_halt = 1'b1;
    #2;
    hold_addr = oam_wr_addr;
    hold_rd   = mem_rd_addr;
    check(oam_wr_en == 1'b0, "R6", "store gated by halt", oam_wr_en, 0);
    repeat (4) begin
      @(negedge clk); #2;
      check(mem_rd_addr == hold_rd, "R6", "read address frozen", mem_rd_addr, hold_rd);
      check(busy == 1'b1, "R6", "busy while halted", busy, 1);
    end
    @(negedge clk);
    cpu_halt = 1'b0;
    #2;
    check(oam_wr_en == 1'b1, "R6", "store resumes", oam_wr_en, 1);
    check(oam_wr_addr == hold_addr, "R6", "resume offset", oam_wr_addr, hold_addr);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cpu_halt = ((i % 5) == 2);
    end
    @(negedge clk);
    cpu_halt = 1'b0;
    wait_idle();

    // Restart mid-transfer: R7
    push_exp(8'h21, 43);
    reg_write(8'h21);
    repeat (42) @(negedge clk);
    push_exp(8'h66, 160);
    reg_write(8'h66);
    #2;
    check(busy == 1'b1, "R7", "busy during restart delay", busy, 1);
    @(negedge clk); #2;
    check(busy == 1'b1, "R7", "busy at restart load", busy, 1);
    check(oam_wr_en == 1'b0, "R7", "restart prime no store", oam_wr_en, 0);
    check(mem_rd_addr == 16'h6600, "R7", "restart read address", mem_rd_addr, 16'h6600);
    wait_idle();

    // Conflict maps: R8, R9, R10
    foreach (pages[pi]) begin
      push_exp(pages[pi], 160);
      reg_write(pages[pi]);
      repeat (3) @(negedge clk);
      foreach (addrs[ai]) begin
        for (int cm = 0; cm < 2; cm++) begin
          bit exp_c;
          @(negedge clk);
          cpu_addr    = addrs[ai];
          color_model = cm[0];
          #2;
          exp_c = ref_conf(pages[pi], addrs[ai], cm[0]);
          check(cpu_conflict == exp_c, cm[0] ? "R8" : "R9", "conflict flag",
                cpu_conflict, exp_c);
          if (exp_c) begin
            check(cpu_eff_addr == mem_rd_addr, "R10", "redirected address",
                  cpu_eff_addr, mem_rd_addr);
            check(cpu_eff_addr[15:8] == pages[pi], "R10", "redirect page",
                  cpu_eff_addr[15:8], pages[pi]);
          end else begin
            check(cpu_eff_addr == addrs[ai], "R10", "unredirected address",
                  cpu_eff_addr, addrs[ai]);
          end
        end
      end
      color_model = 1'b1;
      wait_idle();
    end

    done = 1'b1;
    report();
  end

endmodule